// File: doc/BRIEF.md
# Vectored Interrupt Controller Register Block

This block collects 96 interrupt sources in three banks of 32 and turns them into one processor interrupt line and a vector word. Software reaches its state through a 32-bit register port addressed in bytes. Source n belongs to bank n/32 at bit n%32. Each bank has its own pending, enable and mask words. Every source input passes through a two-flop synchronizer before it is used. Sources 1 to 95 are level-driven: their pending bits copy the synchronized inputs. Source 0 is the external non-maskable line. Its pending bit is set by a trigger condition that software selects, and it stays set until software writes a one to clear it.

A source is active when it is pending, its enable bit is 1 and its mask bit is 0. The interrupt output is high while any source is active. The vector register gives the lowest-numbered active source, shifted left by two. It reads zero when no source is active and also when source 0 is the winner. Software tells these two cases apart by reading bit 0 of pending bank 0.

The request side is a valid/ready stream. `req_ready` is always high, so a request is accepted in every cycle where `req_valid` is high. Read data comes back exactly one cycle after the request, marked by `rsp_valid`. The response path has no back-pressure, so the requester must take each response in the cycle it appears.

Top module: `vic_regblock`

## Requirements
- R1: After reset every stored register is zero, `irq_o` is low and `rsp_valid` is low.
- R2: `req_ready` is always 1. A read accepted at a clock edge gives `rsp_valid`=1 for exactly the following cycle, and `rsp_rdata` holds the register value from before that edge. Writes give no response. Address bits [1:0] are ignored.
- R3: The enable words at byte offsets 0x40, 0x44 and 0x48 and the mask words at 0x50, 0x54 and 0x58 can be read and written in full. Bit k of the word for bank b belongs to source 32*b+k.
- R4: Bit n of the pending words at 0x10, 0x14 and 0x18, for n from 1 to 95, reads as the level of input n sampled three rising edges earlier. Writing these bits has no effect.
- R5: Pending bit 0 is set at any edge where the selected trigger condition holds on the synchronized source-0 input. It is cleared only by writing 1 to bit 0 at offset 0x10. If the set and the clear happen in the same cycle, the set wins.
- R6: The trigger-type word at 0x0C stores bits [1:0], and its other bits read 0. The codes are: 0 = input low, 1 = input high, 2 = falling edge, 3 = rising edge. An edge is a change between two consecutive synchronized samples.
- R7: `irq_o` is 1 exactly when some source is pending, enabled and not masked, with mask bit 0 meaning the source passes.
- R8: A read of 0x00 returns four times the index of the lowest-numbered active source, with bits [1:0] always 0. It returns 0 when no source is active. Writes to 0x00 are ignored.
- R9: The protection word at 0x08 stores bit 0, and its other bits read 0.
- R10: The FIQ-pending words at 0x20, 0x24 and 0x28, and every offset not named above, read as 0. Writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 96 | Raw interrupt source levels; bit 0 is the external non-maskable line |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted; held at 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read request |
| rsp_rdata | output | 32 | Read data |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
A wrong enable, mask or pending bit shows up on `irq_o` in the cycle after the edge that stored it. It also shows up in the vector word on the next read. A fault in the source-0 latch or in its trigger decoding leaves pending bit 0 set or clear against the model. That error persists until the next acknowledge, so it is visible on every later read of 0x10 and on `irq_o` while source 0 is enabled. The reference model steps once per clock, and every cycle it checks `irq_o`, `rsp_valid` and any returned data. A divergence is therefore reported within one cycle of reaching a port.

// File: rtl/vic_pkg.sv
package vic_pkg;
  // Byte offsets of the register map; the bank stride is one word.
  localparam int OFF_VECTOR = 'h00;
  localparam int OFF_PROT   = 'h08;
  localparam int OFF_TRIG   = 'h0C;
  localparam int OFF_PEND   = 'h10;
  localparam int OFF_FIQ    = 'h20;
  localparam int OFF_ENABLE = 'h40;
  localparam int OFF_MASK   = 'h50;

  // Word indices derived from the byte offsets.
  localparam int W_VECTOR = OFF_VECTOR / 4;
  localparam int W_PROT   = OFF_PROT / 4;
  localparam int W_TRIG   = OFF_TRIG / 4;
  localparam int W_PEND   = OFF_PEND / 4;
  localparam int W_FIQ    = OFF_FIQ / 4;
  localparam int W_ENABLE = OFF_ENABLE / 4;
  localparam int W_MASK   = OFF_MASK / 4;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_FALL = 2'd2,
    TRIG_RISE = 2'd3
  } trig_e;
endpackage

// File: rtl/vic_sync.sv
module vic_sync #(
  parameter int W      = 96,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/vic_pending.sv
module vic_pending
  import vic_pkg::*;
#(
  parameter int NSRC = 96
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_s,
  input  trig_e           trig,
  input  logic            nmi_ack,
  output logic [NSRC-1:0] pend_q
);
  logic nmi_prev;
  logic nmi_hit;

  always_comb begin
    unique case (trig)
      TRIG_LOW:  nmi_hit = !src_s[0];
      TRIG_HIGH: nmi_hit = src_s[0];
      TRIG_FALL: nmi_hit = nmi_prev && !src_s[0];
      default:   nmi_hit = !nmi_prev && src_s[0];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= '0;
      nmi_prev <= 1'b0;
    end else begin
      pend_q[NSRC-1:1] <= src_s[NSRC-1:1];
      pend_q[0]        <= nmi_hit || (pend_q[0] && !nmi_ack);
      nmi_prev         <= src_s[0];
    end
  end

  // R5
  nmi_latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q[0] && !nmi_ack) |=> pend_q[0])
    else $error("source 0 pending dropped without acknowledge");
endmodule

// File: rtl/vic_bank_enc.sv
module vic_bank_enc #(
  parameter int W = 32,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  act,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |act;
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (act[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
  parameter int NUM_BANKS = 3,
  parameter int BANK_W    = 32,
  localparam int NSRC     = NUM_BANKS * BANK_W,
  localparam int IDX_W    = $clog2(NSRC),
  localparam int BIDX_W   = (BANK_W > 1) ? $clog2(BANK_W) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  act,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  logic [NUM_BANKS-1:0] bank_any;
  logic [BIDX_W-1:0]    bank_idx [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    vic_bank_enc #(.W(BANK_W)) i_enc (
      .act (act[b*BANK_W +: BANK_W]),
      .any (bank_any[b]),
      .idx (bank_idx[b])
    );
  end

  always_comb begin
    any = |bank_any;
    idx = '0;
    for (int b = NUM_BANKS - 1; b >= 0; b--) begin
      if (bank_any[b]) idx = IDX_W'(b * BANK_W) + IDX_W'(bank_idx[b]);
    end
  end

  // R8
  prio_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> act[idx])
    else $error("winning index is not an active source");

  // R8
  prio_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any |-> (idx == '0))
    else $error("index nonzero with no active source");
endmodule

// File: rtl/vic_regblock.sv
module vic_regblock
  import vic_pkg::*;
#(
  parameter int NUM_BANKS   = 3,
  parameter int BANK_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  localparam int NSRC       = NUM_BANKS * BANK_W,
  localparam int IDX_W      = $clog2(NSRC),
  localparam int WORD_W     = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              irq_o
);
  logic [WORD_W-1:0] word;
  logic              wr, rd;
  logic              unused_addr_lsb;
  logic [NSRC-1:0]   src_s, pend_q, en_q, msk_q, active;
  logic              prot_q;
  trig_e             trig_q;
  logic              nmi_ack;
  logic              prio_any;
  logic [IDX_W-1:0]  prio_idx;
  logic [DATA_W-1:0] rd_data;

  assign req_ready       = 1'b1;
  assign word            = req_addr[ADDR_W-1:2];
  assign unused_addr_lsb = ^req_addr[1:0];
  assign wr              = req_valid && req_write;
  assign rd              = req_valid && !req_write;
  assign nmi_ack         = wr && (int'(word) == W_PEND) && req_wdata[0];

  vic_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) i_sync (
    .clk (clk), .rst_n (rst_n), .d (src_i), .q (src_s)
  );

  vic_pending #(.NSRC(NSRC)) i_pending (
    .clk (clk), .rst_n (rst_n), .src_s (src_s), .trig (trig_q),
    .nmi_ack (nmi_ack), .pend_q (pend_q)
  );

  assign active = pend_q & en_q & ~msk_q;

  vic_prio #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) i_prio (
    .clk (clk), .rst_n (rst_n), .act (active), .any (prio_any), .idx (prio_idx)
  );

  assign irq_o = prio_any;

  // Stored control state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      msk_q  <= '0;
      prot_q <= 1'b0;
      trig_q <= TRIG_LOW;
    end else if (wr) begin
      if (int'(word) == W_PROT) prot_q <= req_wdata[0];
      if (int'(word) == W_TRIG) trig_q <= trig_e'(req_wdata[1:0]);
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (int'(word) == W_ENABLE + b) en_q[b*BANK_W +: BANK_W]  <= req_wdata[BANK_W-1:0];
        if (int'(word) == W_MASK + b)   msk_q[b*BANK_W +: BANK_W] <= req_wdata[BANK_W-1:0];
      end
    end
  end

  // Read multiplexer
  always_comb begin
    rd_data = '0;
    if (int'(word) == W_VECTOR) begin
      rd_data[IDX_W+1:0] = {prio_idx, 2'b00};
    end else if (int'(word) == W_PROT) begin
      rd_data[0] = prot_q;
    end else if (int'(word) == W_TRIG) begin
      rd_data[1:0] = trig_q;
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (int'(word) == W_PEND + b)   rd_data[BANK_W-1:0] = pend_q[b*BANK_W +: BANK_W];
        if (int'(word) == W_ENABLE + b) rd_data[BANK_W-1:0] = en_q[b*BANK_W +: BANK_W];
        if (int'(word) == W_MASK + b)   rd_data[BANK_W-1:0] = msk_q[b*BANK_W +: BANK_W];
      end
    end
  end

  // Response stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_rdata <= rd_data;
    end
  end

  // R2
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write))
    else $error("response without a read request");

  // R7
  winner_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prio_any |-> (en_q[prio_idx] && !msk_q[prio_idx] && pend_q[prio_idx]))
    else $error("winning source is not enabled, unmasked and pending");

  // R9
  prot_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(int'(word) == W_PROT)) |-> (rsp_rdata[DATA_W-1:1] == '0))
    else $error("protection word upper bits nonzero");
endmodule

// File: tb/test_vic_regblock.sv
`timescale 1ns/1ps
module test_vic_regblock;
  localparam int NSRC = 96;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rst_n = 1'b0;
  logic [NSRC-1:0] src = '0;
  logic            req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]      req_addr = '0;
  logic [31:0]     req_wdata = '0;
  logic            req_ready, rsp_valid, irq_o;
  logic [31:0]     rsp_rdata;

  vic_regblock i_vic_regblock (
    .clk (clk), .rst_n (rst_n), .src_i (src),
    .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
    .req_addr (req_addr), .req_wdata (req_wdata),
    .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata), .irq_o (irq_o)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // Behavioural reference state
  bit [NSRC-1:0] m_s1, m_s2, m_pend, m_en, m_msk;
  bit            m_prev, m_prot, m_rv;
  bit [1:0]      m_trig;
  bit [31:0]     m_rd;
  bit [7:0]      m_ra;

  function automatic bit m_irq();
    return |(m_pend & m_en & ~m_msk);
  endfunction

  function automatic bit [31:0] m_read(bit [7:0] a);
    int w = int'(a) / 4;
    bit [31:0] r = '0;
    if (w == 0) begin
      for (int i = NSRC - 1; i >= 0; i--)
        if (m_pend[i] && m_en[i] && !m_msk[i]) r = 32'(i * 4);
    end else if (w == 2) r = {31'b0, m_prot};
    else if (w == 3) r = {30'b0, m_trig};
    else if (w >= 4 && w <= 6) r = m_pend[(w-4)*32 +: 32];
    else if (w >= 16 && w <= 18) r = m_en[(w-16)*32 +: 32];
    else if (w >= 20 && w <= 22) r = m_msk[(w-20)*32 +: 32];
    return r;
  endfunction

  function automatic string req_of(bit [7:0] a);
    int w = int'(a) / 4;
    if (w == 0) return "R8";
    if (w == 2) return "R9";
    if (w == 3) return "R6";
    if (w == 4) return "R4/R5";
    if (w == 5 || w == 6) return "R4";
    if ((w >= 16 && w <= 18) || (w >= 20 && w <= 22)) return "R3";
    return "R10";
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_pend = '0; m_en = '0; m_msk = '0;
      m_prev = 0; m_prot = 0; m_rv = 0; m_trig = 0; m_rd = '0; m_ra = '0;
    end else begin
      bit hit;
      bit [NSRC-1:0] np;
      int w;
      w = int'(req_addr) / 4;
      case (m_trig)
        2'd0: hit = !m_s2[0];
        2'd1: hit = m_s2[0];
        2'd2: hit = m_prev && !m_s2[0];
        default: hit = !m_prev && m_s2[0];
      endcase
      m_rv = req_valid && !req_write;
      if (m_rv) begin m_rd = m_read(req_addr); m_ra = req_addr; end
      np = m_s2;
      np[0] = m_pend[0];
      if (req_valid && req_write && w == 4 && req_wdata[0]) np[0] = 1'b0;
      if (hit) np[0] = 1'b1;
      if (req_valid && req_write) begin
        if (w == 2) m_prot = req_wdata[0];
        if (w == 3) m_trig = req_wdata[1:0];
        if (w >= 16 && w <= 18) m_en[(w-16)*32 +: 32] = req_wdata;
        if (w >= 20 && w <= 22) m_msk[(w-20)*32 +: 32] = req_wdata;
      end
      m_pend = np;
      m_prev = m_s2[0];
      m_s2 = m_s1;
      m_s1 = src;
    end
  end

  task automatic chk(bit ok, string r, bit [31:0] act, bit [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", r, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(irq_o == m_irq(), "R7", 32'(irq_o), 32'(m_irq()));
      chk(rsp_valid == m_rv && req_ready, "R2", {30'b0, req_ready, rsp_valid}, {30'b0, 1'b1, m_rv});
      if (m_rv && rsp_valid) chk(rsp_rdata == m_rd, req_of(m_ra), rsp_rdata, m_rd);
    end
  end

  task automatic acc(bit w, bit [7:0] a, bit [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic set_src(bit [NSRC-1:0] v);
    @(negedge clk);
    src = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    chk(irq_o == 1'b0 && rsp_valid == 1'b0, "R1", {30'b0, irq_o, rsp_valid}, '0);
    for (int a = 0; a < 'h60; a += 4) acc(0, 8'(a), '0);
    acc(0, 8'h41, '0);  // R2 low address bits ignored

    // R3 enable everything; source 0 latches under low-level trigger (R5)
    acc(1, 8'h40, 32'hFFFF_FFFF); acc(1, 8'h44, 32'hFFFF_FFFF); acc(1, 8'h48, 32'hFFFF_FFFF);
    acc(0, 8'h10, '0);
    acc(0, 8'h00, '0);  // R8 vector zero while source 0 wins
    acc(1, 8'h0C, 32'hFFFF_FFFD); // R6 high-level trigger, upper bits dropped
    acc(0, 8'h0C, '0);
    acc(1, 8'h10, 32'h1); acc(0, 8'h10, '0);
    set_src((NSRC'(1) << 37) | (NSRC'(1) << 70));
    acc(0, 8'h00, '0);  // R8 expect 37*4
    acc(1, 8'h54, 32'h20); acc(0, 8'h00, '0);  // mask 37 -> 70 wins
    acc(1, 8'h18, 32'hFFFF_FFFF); acc(0, 8'h18, '0);  // R4 W1C no effect
    acc(1, 8'h48, 32'h0); acc(0, 8'h00, '0);  // gated: no source
    set_src('0);

    // R5/R6 every trigger type
    for (int m = 0; m < 4; m++) begin
      acc(1, 8'h0C, 32'(m));
      acc(1, 8'h10, 32'h1);
      set_src(NSRC'(1)); acc(0, 8'h10, '0);
      set_src('0);       acc(0, 8'h10, '0);
      acc(1, 8'h10, 32'h1); acc(0, 8'h10, '0);
    end

    // R9 / R10
    acc(1, 8'h08, 32'hFFFF_FFFF); acc(0, 8'h08, '0);
    acc(1, 8'h20, 32'hFFFF_FFFF); acc(0, 8'h20, '0);
    acc(1, 8'h30, 32'hFFFF_FFFF); acc(0, 8'h30, '0);
    acc(1, 8'h00, 32'hFFFF_FFFF); acc(0, 8'h00, '0);
    acc(1, 8'h5C, 32'hFFFF_FFFF); acc(0, 8'h5C, '0);

    // Mixed traffic
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if ($urandom % 4 == 0) src = src ^ {$urandom, $urandom, $urandom};
      req_valid = ($urandom % 2) == 1;
      req_write = ($urandom % 3) == 0;
      req_addr  = 8'(($urandom % 24) * 4 + (($urandom % 8 == 0) ? 1 : 0));
      req_wdata = ($urandom % 2 == 1) ? $urandom : {$urandom % 2 == 1 ? 16'hFFFF : 16'h0, 16'($urandom)};
    end
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    done = 1'b1;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule